// File: doc/BRIEF.md
# Instruction Length Decoder for a Byte-Coded 32-bit Instruction Set

This block takes a stream of instruction bytes, one per cycle, through a valid/ready handshake. It finds the last byte of each instruction. The instruction set is a 32-bit CISC format with variable length. The decoder works through each instruction in stages: any number of prefixes, an opcode of one byte or of two bytes behind an escape, an optional operand specifier byte, an optional scale/index/base byte, and a tail made of displacement and immediate bytes.

The cycle after the final byte of an instruction is accepted, the decoder pulses an end flag. At the same time it reports the total byte count, prefixes included. If the opcode lies outside the supported core subset, the decoder flags it as unknown and ends the instruction at that byte, so that decoding can resynchronise on the next byte. The block executes nothing.

Top module: `insn_len_decoder`

## Requirements
- R1: Bytes 0x66, 0x67, 0xF0, 0xF2 and 0xF3 seen in opcode position are prefixes, in any number, and each one counts toward the length. Only 0x66 changes a later size; 0x67 changes no length.
- R2: 0x0F is an escape, and the following byte picks the instruction. In that second position, 0x80–0x8F take 4 displacement bytes; 0x90–0x9F, 0xAF, 0xB6, 0xB7, 0xBE and 0xBF take a specifier byte; 0xC8–0xCF are complete. Any other second byte is unknown.
- R3: The specifier byte has mode in bits 7:6, reg in bits 5:3 and rm in bits 2:0. Mode 3 adds no displacement, mode 1 adds 1 byte and mode 2 adds 4 bytes.
- R4: Mode 0 with rm=5 adds a 4-byte displacement. Mode 0 with any other rm except 4 adds none.
- R5: rm=4 with a mode other than 3 inserts a scale/index/base byte, whose base field is bits 2:0. The displacement is then 1 byte for mode 1 and 4 bytes for mode 2. For mode 0 it is 4 bytes when base=5 and none otherwise.
- R6: For ALU, move and test forms, opcode bit 0 = 0 selects a 1-byte immediate. Bit 0 = 1 selects a word immediate: 4 bytes, or 2 bytes when a 0x66 prefix is present. Tail bytes are never read as prefixes.
- R7: 0x80 and 0x83 take a specifier and a 1-byte immediate, while 0x81 takes a specifier and a word immediate. 0x82 is unknown.
- R8: 0xB0–0xB7 take a 1-byte immediate and 0xB8–0xBF take a word immediate. Neither range has a specifier byte.
- R9: 0x70–0x7F carry a 1-byte displacement. 0xE8 and 0xE9 carry a word displacement (2 bytes after 0x66).
- R10: 0xF6/0xF7 take a specifier byte. An immediate (1 byte for 0xF6, a word for 0xF7) follows only when reg=0.
- R11: 0xC2 carries a 2-byte immediate whatever the prefixes. 0x40–0x5F are single-byte instructions.
- R12: An unsupported opcode ends the instruction at that byte with end_unknown=1. Prefix state is cleared at every instruction end.
- R13: end_pulse is high for exactly the cycle after the last byte is accepted, with end_len equal to the total byte count. The count saturates at 2^LEN_W-1. end_len holds between pulses.
- R14: in_ready is low during reset and high from the cycle after. A cycle with in_valid low consumes nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | in_byte holds a stream byte |
| in_byte | input | 8 | Instruction stream byte |
| in_ready | output | 1 | Decoder accepts a byte this cycle |
| end_pulse | output | 1 | One-cycle flag: an instruction ended on the last accepted byte |
| end_len | output | LEN_W | Byte count of the ended instruction |
| end_unknown | output | 1 | The ended instruction had an unsupported opcode |

## Verification
The bound checker watches the output protocol on every cycle. It checks that an end pulse follows only an accepted byte, that the unknown flag never appears without a pulse, that a reported length is never zero, that the length stays stable between pulses, and that ready returns after reset. The length values themselves depend on the byte sequence: specifier modes, the scale/index/base special cases, width and sign-extend bits, the operand-size prefix, unknown-opcode resynchronisation, saturation and gaps in valid. These can only be shown by the bench's scenarios, which compare each reported length against a queue of lengths derived from the requirements.

// File: rtl/ild_pkg.sv
package ild_pkg;

  localparam logic [7:0] BYTE_OPSZ = 8'h66;

  typedef enum logic [2:0] {
    ST_OPC,
    ST_ESC,
    ST_XRM,
    ST_SIB,
    ST_TAIL
  } seq_st_e;

  // size class of the bytes that follow the opcode (besides specifier/sib)
  typedef enum logic [2:0] {
    TK_NONE,
    TK_B1,
    TK_B2,
    TK_B3,
    TK_B4,
    TK_WORD
  } tail_kind_e;

  typedef struct packed {
    logic       bad;
    logic       is_pfx;
    logic       is_esc;
    logic       has_xrm;
    logic       grp_test;
    tail_kind_e tail;
  } op_info_t;

  function automatic logic [2:0] tail_bytes(input tail_kind_e k, input logic opsz16);
    case (k)
      TK_B1:   tail_bytes = 3'd1;
      TK_B2:   tail_bytes = 3'd2;
      TK_B3:   tail_bytes = 3'd3;
      TK_B4:   tail_bytes = 3'd4;
      TK_WORD: tail_bytes = opsz16 ? 3'd2 : 3'd4;
      default: tail_bytes = 3'd0;
    endcase
  endfunction

endpackage

// File: rtl/ild_opclass.sv
module ild_opclass
  import ild_pkg::*;
(
  input  logic [7:0] opc,
  input  logic       esc,
  output op_info_t   info
);

  always_comb begin
    info      = '0;
    info.tail = TK_NONE;
    if (esc) begin
      casez (opc)
        8'h8?:                          info.tail = TK_B4;
        8'h9?:                          info.has_xrm = 1'b1;
        8'hAF, 8'hB6, 8'hB7, 8'hBE,
        8'hBF:                          info.has_xrm = 1'b1;
        8'b1100_1???:                   ;
        default:                        info.bad = 1'b1;
      endcase
    end else if (opc < 8'h40) begin
      if (opc == 8'h0F) begin
        info.is_esc = 1'b1;
      end else begin
        case (opc[2:0])
          3'd0, 3'd1, 3'd2, 3'd3: info.has_xrm = 1'b1;
          3'd4:                   info.tail = TK_B1;
          3'd5:                   info.tail = TK_WORD;
          3'd7:                   info.bad = ~opc[5];
          default:                info.bad = 1'b1;
        endcase
      end
    end else begin
      casez (opc)
        8'b010?_????:                   ;
        8'h60, 8'h61:                   ;
        8'h66, 8'h67:                   info.is_pfx = 1'b1;
        8'h68:                          info.tail = TK_WORD;
        8'h69: begin info.has_xrm = 1'b1; info.tail = TK_WORD; end
        8'h6A:                          info.tail = TK_B1;
        8'h6B: begin info.has_xrm = 1'b1; info.tail = TK_B1; end
        8'b0110_11??:                   ;
        8'h7?:                          info.tail = TK_B1;
        8'h80, 8'h83: begin info.has_xrm = 1'b1; info.tail = TK_B1; end
        8'h81: begin info.has_xrm = 1'b1; info.tail = TK_WORD; end
        8'b1000_01??, 8'b1000_1???:     info.has_xrm = 1'b1;
        8'b1001_0???:                   ;
        8'h98, 8'h99, 8'h9B,
        8'b1001_11??:                   ;
        8'b1010_00??:                   info.tail = TK_B4;
        8'b1010_01??:                   ;
        8'hA8:                          info.tail = TK_B1;
        8'hA9:                          info.tail = TK_WORD;
        8'hAA, 8'hAB,
        8'b1010_11??:                   ;
        8'b1011_0???:                   info.tail = TK_B1;
        8'b1011_1???:                   info.tail = TK_WORD;
        8'hC0, 8'hC1, 8'hC6: begin info.has_xrm = 1'b1; info.tail = TK_B1; end
        8'hC7: begin info.has_xrm = 1'b1; info.tail = TK_WORD; end
        8'hC2, 8'hCA:                   info.tail = TK_B2;
        8'hC8:                          info.tail = TK_B3;
        8'hCD:                          info.tail = TK_B1;
        8'hC3, 8'hC9, 8'hCB, 8'hCC,
        8'hCE, 8'hCF:                   ;
        8'b1101_00??:                   info.has_xrm = 1'b1;
        8'hD4, 8'hD5:                   info.tail = TK_B1;
        8'hD7:                          ;
        8'b1110_0???, 8'hEB:            info.tail = TK_B1;
        8'hE8, 8'hE9:                   info.tail = TK_WORD;
        8'b1110_11??:                   ;
        8'hF0, 8'hF2, 8'hF3:            info.is_pfx = 1'b1;
        8'hF4, 8'hF5:                   ;
        8'hF6: begin info.has_xrm = 1'b1; info.grp_test = 1'b1; info.tail = TK_B1; end
        8'hF7: begin info.has_xrm = 1'b1; info.grp_test = 1'b1; info.tail = TK_WORD; end
        8'b1111_10??, 8'hFC, 8'hFD:     ;
        8'hFE, 8'hFF:                   info.has_xrm = 1'b1;
        default:                        info.bad = 1'b1;
      endcase
    end
  end

endmodule

// File: rtl/ild_addrmode.sv
module ild_addrmode (
  input  logic       sib_phase,
  input  logic [1:0] mode,
  input  logic [2:0] rm_or_base,
  output logic       need_sib,
  output logic [2:0] disp_bytes
);

  always_comb begin
    need_sib = !sib_phase && (mode != 2'd3) && (rm_or_base == 3'd4);
    case (mode)
      2'd0:    disp_bytes = (rm_or_base == 3'd5) ? 3'd4 : 3'd0;
      2'd1:    disp_bytes = 3'd1;
      2'd2:    disp_bytes = 3'd4;
      default: disp_bytes = 3'd0;
    endcase
  end

endmodule

// File: rtl/ild_seq.sv
module ild_seq
  import ild_pkg::*;
#(
  parameter int LEN_W = 5
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             take,
  input  logic [7:0]       byte_in,
  input  op_info_t         info,
  input  logic             need_sib,
  input  logic [2:0]       disp_bytes,
  output seq_st_e          st,
  output logic [1:0]       mode_saved,
  output logic             ready,
  output logic             end_pulse,
  output logic [LEN_W-1:0] end_len,
  output logic             end_unknown
);

  localparam int REM_W = 4;

  seq_st_e          st_q, st_d;
  logic [LEN_W-1:0] len_q, len_inc;
  logic [REM_W-1:0] rem_q, rem_d, tail_sum;
  logic [2:0]       imm_q, imm_d, imm_now;
  logic             test_q, test_d, opsz_q, opsz_d;
  logic [1:0]       mode_q, mode_d;
  logic             done, unk;
  logic             ready_q, pulse_q, unk_q;
  logic [LEN_W-1:0] elen_q;

  assign len_inc = (len_q == {LEN_W{1'b1}}) ? len_q : len_q + 1'b1;
  assign imm_now = tail_bytes(info.tail, opsz_q);

  always_comb begin
    st_d     = st_q;
    rem_d    = rem_q;
    imm_d    = imm_q;
    test_d   = test_q;
    mode_d   = mode_q;
    opsz_d   = opsz_q;
    done     = 1'b0;
    unk      = 1'b0;
    tail_sum = '0;
    case (st_q)
      ST_OPC, ST_ESC: begin
        if (info.is_pfx) begin
          if (byte_in == BYTE_OPSZ) opsz_d = 1'b1;
        end else if (info.is_esc) begin
          st_d = ST_ESC;
        end else if (info.bad) begin
          done = 1'b1;
          unk  = 1'b1;
        end else if (info.has_xrm) begin
          st_d   = ST_XRM;
          imm_d  = imm_now;
          test_d = info.grp_test;
        end else if (imm_now == 3'd0) begin
          done = 1'b1;
        end else begin
          st_d  = ST_TAIL;
          rem_d = {1'b0, imm_now};
        end
      end
      ST_XRM: begin
        imm_d  = (test_q && byte_in[5:3] != 3'd0) ? 3'd0 : imm_q;
        mode_d = byte_in[7:6];
        if (need_sib) begin
          st_d = ST_SIB;
        end else begin
          tail_sum = {1'b0, disp_bytes} + {1'b0, imm_d};
          if (tail_sum == '0) done = 1'b1;
          else begin
            st_d  = ST_TAIL;
            rem_d = tail_sum;
          end
        end
      end
      ST_SIB: begin
        tail_sum = {1'b0, disp_bytes} + {1'b0, imm_q};
        if (tail_sum == '0) done = 1'b1;
        else begin
          st_d  = ST_TAIL;
          rem_d = tail_sum;
        end
      end
      ST_TAIL: begin
        if (rem_q == 4'd1) done = 1'b1;
        else rem_d = rem_q - 1'b1;
      end
      default: st_d = ST_OPC;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q    <= ST_OPC;
      len_q   <= '0;
      rem_q   <= '0;
      imm_q   <= '0;
      test_q  <= 1'b0;
      opsz_q  <= 1'b0;
      mode_q  <= '0;
      ready_q <= 1'b0;
      pulse_q <= 1'b0;
      unk_q   <= 1'b0;
      elen_q  <= '0;
    end else begin
      ready_q <= 1'b1;
      pulse_q <= take && done;
      unk_q   <= take && done && unk;
      if (take) begin
        if (done) begin
          st_q   <= ST_OPC;
          len_q  <= '0;
          opsz_q <= 1'b0;
          test_q <= 1'b0;
          elen_q <= len_inc;
        end else begin
          st_q   <= st_d;
          len_q  <= len_inc;
          opsz_q <= opsz_d;
          test_q <= test_d;
        end
        rem_q  <= rem_d;
        imm_q  <= imm_d;
        mode_q <= mode_d;
      end
    end
  end

  assign st          = st_q;
  assign mode_saved  = mode_q;
  assign ready       = ready_q;
  assign end_pulse   = pulse_q;
  assign end_len     = elen_q;
  assign end_unknown = unk_q;

endmodule

// File: rtl/insn_len_decoder.sv
module insn_len_decoder
  import ild_pkg::*;
#(
  parameter int LEN_W = 5
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             in_valid,
  input  logic [7:0]       in_byte,
  output logic             in_ready,
  output logic             end_pulse,
  output logic [LEN_W-1:0] end_len,
  output logic             end_unknown
);

  seq_st_e    st;
  op_info_t   info;
  logic [1:0] mode_saved, am_mode;
  logic       need_sib, take;
  logic [2:0] disp_bytes;

  assign take    = in_valid && in_ready;
  assign am_mode = (st == ST_SIB) ? mode_saved : in_byte[7:6];

  ild_opclass u_opclass (
    .opc  (in_byte),
    .esc  (st == ST_ESC),
    .info (info)
  );

  ild_addrmode u_addrmode (
    .sib_phase  (st == ST_SIB),
    .mode       (am_mode),
    .rm_or_base (in_byte[2:0]),
    .need_sib   (need_sib),
    .disp_bytes (disp_bytes)
  );

  ild_seq #(.LEN_W(LEN_W)) u_seq (
    .clk         (clk),
    .rst         (rst),
    .take        (take),
    .byte_in     (in_byte),
    .info        (info),
    .need_sib    (need_sib),
    .disp_bytes  (disp_bytes),
    .st          (st),
    .mode_saved  (mode_saved),
    .ready       (in_ready),
    .end_pulse   (end_pulse),
    .end_len     (end_len),
    .end_unknown (end_unknown)
  );

endmodule

// File: rtl/ild_chk.sv
module ild_chk #(
  parameter int LEN_W = 5
) (
  input logic             clk,
  input logic             rst,
  input logic             in_valid,
  input logic             in_ready,
  input logic             end_pulse,
  input logic [LEN_W-1:0] end_len,
  input logic             end_unknown
);

  // R14
  ready_back_chk: assert property (@(posedge clk) disable iff (rst)
    $past(!rst) |-> in_ready);

  // R13
  pulse_after_take_chk: assert property (@(posedge clk) disable iff (rst)
    end_pulse |-> $past(in_valid && in_ready));

  // R12
  unknown_with_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    end_unknown |-> end_pulse);

  // R13
  len_nonzero_chk: assert property (@(posedge clk) disable iff (rst)
    end_pulse |-> (end_len != '0));

  // R13
  len_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !end_pulse |-> $stable(end_len));

endmodule

bind insn_len_decoder ild_chk #(.LEN_W(LEN_W)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .in_valid    (in_valid),
  .in_ready    (in_ready),
  .end_pulse   (end_pulse),
  .end_len     (end_len),
  .end_unknown (end_unknown)
);

// File: tb/sim_insn_len_decoder.sv
`timescale 1ns/1ps
module sim_insn_len_decoder;

  localparam int LEN_W = 5;

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic             in_valid = 1'b0;
  logic [7:0]       in_byte = 8'h00;
  logic             in_ready, end_pulse, end_unknown;
  logic [LEN_W-1:0] end_len;

  typedef struct {
    int    len;
    bit    unk;
    string req;
  } exp_t;

  exp_t       exp_q[$];
  logic [7:0] stim[$];
  int         checks = 0;
  int         fails = 0;
  bit         finished = 0;

  always #4 clk = ~clk;

  insn_len_decoder #(.LEN_W(LEN_W)) u0 (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_byte(in_byte),
    .in_ready(in_ready), .end_pulse(end_pulse), .end_len(end_len),
    .end_unknown(end_unknown)
  );

  task automatic b(input logic [7:0] x);
    stim.push_back(x);
  endtask

  task automatic bn(input int n, input logic [7:0] x);
    for (int i = 0; i < n; i++) stim.push_back(x);
  endtask

  // driver: queue the expectation, then stream the bytes
  task automatic send(input int exp_len, input bit exp_unk, input string req, input bit gap);
    exp_t e;
    e.len = exp_len; e.unk = exp_unk; e.req = req;
    exp_q.push_back(e);
    while (stim.size() > 0) begin
      @(negedge clk);
      in_valid = 1'b1;
      in_byte  = stim.pop_front();
      if (gap) begin
        @(negedge clk);
        in_valid = 1'b0;
        in_byte  = 8'h90;
      end
    end
  endtask

  // monitor / scoreboard
  always @(negedge clk) begin
    if (!rst && end_pulse) begin
      checks++;
      if (exp_q.size() == 0) begin
        fails++;
        $display("FAIL R13 unexpected end: actual len=%0d expected no end", end_len);
      end else begin
        exp_t e;
        e = exp_q.pop_front();
        if (int'(end_len) != e.len) begin
          fails++;
          $display("FAIL %s length: actual=%0d expected=%0d", e.req, end_len, e.len);
        end
        checks++;
        if (end_unknown != e.unk) begin
          fails++;
          $display("FAIL %s unknown flag: actual=%0b expected=%0b", e.req, end_unknown, e.unk);
        end
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      fails++;
      $display("FAIL R13 watchdog: actual=timeout expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    checks++;
    if (in_ready !== 1'b0) begin
      fails++; $display("FAIL R14 ready in reset: actual=%b expected=0", in_ready);
    end
    rst = 1'b0;
    repeat (2) @(negedge clk);
    checks++;
    if (in_ready !== 1'b1) begin
      fails++; $display("FAIL R14 ready after reset: actual=%b expected=1", in_ready);
    end
    checks++;
    if (end_pulse !== 1'b0 || end_len !== '0) begin
      fails++; $display("FAIL R13 reset outputs: actual=%b/%0d expected=0/0", end_pulse, end_len);
    end

    // R1 prefixes
    b(8'h66); b(8'hF3); b(8'h90);               send(3, 0, "R1", 0);
    b(8'hF0); b(8'hF2); b(8'h67); b(8'h40);     send(4, 0, "R1", 0);
    b(8'h67); b(8'h8B); b(8'h05); bn(4, 8'h11); send(7, 0, "R1", 0);
    // R2 escape
    b(8'h0F); b(8'hAF); b(8'hC0);               send(3, 0, "R2", 0);
    b(8'h0F); b(8'hB6); b(8'h45); b(8'h08);     send(4, 0, "R2", 0);
    b(8'h0F); b(8'hC9);                         send(2, 0, "R2", 0);
    // R3 modes
    b(8'h01); b(8'hC8);                         send(2, 0, "R3", 0);
    b(8'h01); b(8'h48); b(8'h10);               send(3, 0, "R3", 0);
    b(8'h01); b(8'h88); bn(4, 8'h22);           send(6, 0, "R3", 0);
    // R4 mode 0
    b(8'h8B); b(8'h05); bn(4, 8'h33);           send(6, 0, "R4", 0);
    b(8'h8B); b(8'h03);                         send(2, 0, "R4", 0);
    // R5 sib
    b(8'h8B); b(8'h04); b(8'h24);               send(3, 0, "R5", 0);
    b(8'h8B); b(8'h44); b(8'h24); b(8'h08);     send(4, 0, "R5", 0);
    b(8'h8B); b(8'h04); b(8'h25); bn(4, 8'h44); send(7, 0, "R5", 0);
    b(8'h8B); b(8'h84); b(8'h24); bn(4, 8'h55); send(7, 0, "R5", 0);
    b(8'h8B); b(8'hC4);                         send(2, 0, "R5", 0);
    // R6 width and operand size
    b(8'h04); b(8'h7F);                         send(2, 0, "R6", 0);
    b(8'h05); bn(4, 8'h66);                     send(5, 0, "R6", 0);
    b(8'h66); b(8'h05); bn(2, 8'h01);           send(4, 0, "R6", 0);
    b(8'hC6); b(8'h00); b(8'h12);               send(3, 0, "R6", 0);
    b(8'hC7); b(8'h00); bn(4, 8'h0F);           send(6, 0, "R6", 0);
    b(8'h66); b(8'hC7); b(8'h44); b(8'h24); b(8'h08); bn(2, 8'h77); send(7, 0, "R6", 0);
    // R7 immediate ALU group
    b(8'h80); b(8'hC0); b(8'h01);               send(3, 0, "R7", 0);
    b(8'h81); b(8'hC0); bn(4, 8'h02);           send(6, 0, "R7", 0);
    b(8'h83); b(8'hC0); b(8'h03);               send(3, 0, "R7", 0);
    b(8'h66); b(8'h81); b(8'hC0); bn(2, 8'h04); send(5, 0, "R7", 0);
    b(8'h82);                                   send(1, 1, "R7", 0);
    // R8 move immediate to register
    b(8'hB3); b(8'h09);                         send(2, 0, "R8", 0);
    b(8'hBA); bn(4, 8'h09);                     send(5, 0, "R8", 0);
    b(8'h66); b(8'hB8); bn(2, 8'h09);           send(4, 0, "R8", 0);
    // R9 branches
    b(8'h75); b(8'hFE);                         send(2, 0, "R9", 0);
    b(8'hE8); bn(4, 8'h00);                     send(5, 0, "R9", 0);
    b(8'h66); b(8'hE9); bn(2, 8'h00);           send(4, 0, "R9", 0);
    b(8'h0F); b(8'h8F); bn(4, 8'h00);           send(6, 0, "R9", 0);
    // R10 unary group
    b(8'hF6); b(8'hC0); b(8'h01);               send(3, 0, "R10", 0);
    b(8'hF7); b(8'hC0); bn(4, 8'h01);           send(6, 0, "R10", 0);
    b(8'hF7); b(8'hD8);                         send(2, 0, "R10", 0);
    b(8'hF6); b(8'hE0);                         send(2, 0, "R10", 0);
    b(8'hF7); b(8'h05); bn(8, 8'h01);           send(10, 0, "R10", 0);
    // R11 return-with-pop and single-byte register forms
    b(8'hC2); bn(2, 8'h08);                     send(3, 0, "R11", 0);
    b(8'h66); b(8'hC2); bn(2, 8'h08);           send(4, 0, "R11", 0);
    b(8'h40);                                   send(1, 0, "R11", 0);
    b(8'h5F);                                   send(1, 0, "R11", 0);
    // R12 unknown opcodes and resync, prefix state cleared
    b(8'hD8);                                   send(1, 1, "R12", 0);
    b(8'h66); b(8'hD9);                         send(2, 1, "R12", 0);
    b(8'h05); bn(4, 8'h01);                     send(5, 0, "R12", 0);
    b(8'h0F); b(8'h05);                         send(2, 1, "R12", 0);
    b(8'h90);                                   send(1, 0, "R12", 0);
    // R13 length saturation
    bn(40, 8'hF0); b(8'h90);                    send(31, 0, "R13", 0);
    b(8'h90);                                   send(1, 0, "R13", 0);
    // R14 gaps in valid carry ignored bytes
    b(8'h81); b(8'h84); b(8'h24); bn(4, 8'h10); bn(4, 8'h20); send(11, 0, "R14", 1);
    b(8'h66); b(8'hB8); bn(2, 8'h09);           send(4, 0, "R14", 1);

    @(negedge clk);
    in_valid = 1'b0;
    repeat (8) @(negedge clk);
    checks++;
    if (exp_q.size() != 0) begin
      fails++;
      $display("FAIL R13 missing ends: actual=%0d pending expected=0", exp_q.size());
    end
    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule